// File: doc/BRIEF.md
# Modulo Timer with Interlocked Overflow Flag

This block is a 16-bit up-counter clocked by a power-of-two prescaler. It wraps at a programmable modulo limit. Each time the count reaches the limit, an overflow flag is raised, and an enable bit turns that flag into a level interrupt request. Software uses a small byte-wide register port to control the block: it starts, stops and zeroes the counter, selects the prescale ratio, sets the limit, and reads the running count.

The overflow flag does not clear on a plain write. Software must first read the control byte and see the flag at 1, then write the control byte with the flag bit at 0. If a new overflow occurs between that read and that write, the pending clear is cancelled. An interrupt that arrives during the clear sequence is therefore kept. After reset the counter is stopped, the flag and the enable are low, and the limit is all ones.

Top module: `modulo_timer`

## Requirements
- R1: After reset the control byte (address 0) reads 0x20, both count bytes read 0x00, and `irq` is low.
- R2: The control byte reads as {flag[7], irq enable[6], stop[5], 0[4], 0[3], prescale code[2:0]}. A write sets the enable, stop and prescale fields from the same bit positions. Bits 4 and 3 always read 0.
- R3: Address 1 reads the count high byte and address 2 the count low byte; both are read-only. Addresses 3 and 4 are the limit high and low bytes, readable and writable, reset to 0xFF each. While running, the count rises by one on each prescaled tick.
- R4: Prescale code k in 0..6 produces one tick every 2^k clocks. Code 7 produces one tick every 64 clocks.
- R5: A tick that moves the count to the limit value sets the flag. The next tick taken at the limit returns the count to 0x0000.
- R6: While stop is 1, the count and the prescaler phase do not change. Register reads and writes still operate.
- R7: A control write with bit 4 at 1 sets the count and the prescaler phase to 0. The fields of that write still take effect.
- R8: A control write with bit 7 at 0 clears the flag if an earlier control read returned bit 7 at 1 and no other control write came in between.
- R9: A control write with bit 7 at 0 does not clear the flag when no such read preceded it. Writing 1 to bit 7 never sets the flag.
- R10: An overflow that occurs after the arming read cancels the clear, and the flag stays 1 through the following write of 0.
- R11: `irq` is high exactly when the flag and the enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` while `bus_rd` is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
A fault in the prescaler phase or the count register appears in the next count read as an off-by-some value. After a stop or a restart, the same fault appears as a shifted wrap point. A fault in the hidden arm bit cannot be seen directly. It shows on the control byte read one cycle after the clearing write: the flag is either still set or wrongly dropped. `irq` shows the same error on that cycle. Overflows are timed to fall between the arming read and the write, and away from the write itself. A cancel fault therefore produces exactly one wrong flag value that can be observed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;
    localparam int PS_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_CNT_HI = 3'd1,
        RA_CNT_LO = 3'd2,
        RA_LIM_HI = 3'd3,
        RA_LIM_LO = 3'd4
    } reg_addr_e;

    // control byte bit positions
    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_STOP = 5;
    localparam int B_ZERO = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            zero,
    input  logic [PS_W-1:0] code,
    output logic            tick
);
    localparam logic [PRE_W:0] ONE_W = (PRE_W+1)'(1);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PS_W-1:0]  sel;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;

    always_comb begin
        // codes beyond the prescaler width saturate at the widest ratio
        if (int'(code) > PRE_W) sel = PS_W'(PRE_W);
        else                    sel = code;
        span = (ONE_W << sel) - ONE_W;
        mask = span[PRE_W-1:0];
        tick = run && ((st_q.phase & mask) == mask);

        st_d = st_q;
        if (zero)     st_d.phase = '0;
        else if (run) st_d.phase = st_q.phase + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16   // 9..16: two byte-wide limit registers
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             zero,
    input  logic             lim_wr_hi,
    input  logic             lim_wr_lo,
    input  logic [7:0]       wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             ovf
);
    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        stepped = (st_q.cnt == st_q.lim) ? '0 : st_q.cnt + ONE;
        ovf     = tick && !zero && (stepped == st_q.lim);

        st_d = st_q;
        if (lim_wr_hi) st_d.lim[CNT_W-1:8] = wdata[HI_W-1:0];
        if (lim_wr_lo) st_d.lim[7:0]       = wdata;
        if (zero)      st_d.cnt = '0;
        else if (tick) st_d.cnt = stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lim <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign limit = st_q.lim;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            rd,
    input  logic            wr,
    input  logic [7:0]      wdata,
    input  logic            ovf,
    output logic            flag,
    output logic            ie,
    output logic            stop,
    output logic [PS_W-1:0] code,
    output logic            zero,
    output logic            irq
);
    typedef struct packed {
        logic            flag;
        logic            ie;
        logic            stop;
        logic [PS_W-1:0] code;
        logic            armed;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       acc_rd, acc_wr;
    logic       ctrl_unused_bit;

    assign ctrl_unused_bit = wdata[3];

    always_comb begin
        acc_rd = rd && sel;
        acc_wr = wr && sel;
        zero   = acc_wr && wdata[B_ZERO];

        st_d = st_q;
        if (acc_wr) begin
            st_d.ie   = wdata[B_IE];
            st_d.stop = wdata[B_STOP];
            st_d.code = wdata[PS_W-1:0];
        end
        // a read that sees the flag high arms the clear
        if (acc_rd && st_q.flag) st_d.armed = 1'b1;
        if (acc_wr) begin
            st_d.armed = 1'b0;
            if (!wdata[B_FLAG] && st_q.armed) st_d.flag = 1'b0;
        end
        // a fresh overflow wins over any pending clear
        if (ovf) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stop <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign ie   = st_q.ie;
    assign stop = st_q.stop;
    assign code = st_q.code;
    assign irq  = st_q.flag && st_q.ie;
endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    logic             tick_w, zero_w, ovf_w;
    logic             flag_w, ie_w, stop_w;
    logic [PS_W-1:0]  code_w;
    logic [CNT_W-1:0] cnt_w, lim_w;
    logic             ctrl_sel;

    assign ctrl_sel = (bus_addr == RA_CTRL);

    tmr_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_sel),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .ovf   (ovf_w),
        .flag  (flag_w),
        .ie    (ie_w),
        .stop  (stop_w),
        .code  (code_w),
        .zero  (zero_w),
        .irq   (irq)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (!stop_w),
        .zero  (zero_w),
        .code  (code_w),
        .tick  (tick_w)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .zero      (zero_w),
        .lim_wr_hi (bus_wr && bus_addr == RA_LIM_HI),
        .lim_wr_lo (bus_wr && bus_addr == RA_LIM_LO),
        .wdata     (bus_wdata),
        .count     (cnt_w),
        .limit     (lim_w),
        .ovf       (ovf_w)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                RA_CTRL:   bus_rdata = {flag_w, ie_w, stop_w, 2'b00, code_w};
                RA_CNT_HI: bus_rdata = 8'(cnt_w >> 8);
                RA_CNT_LO: bus_rdata = cnt_w[7:0];
                RA_LIM_HI: bus_rdata = 8'(lim_w >> 8);
                RA_LIM_LO: bus_rdata = lim_w[7:0];
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  lim,
    input  logic              flag,
    input  logic              stop,
    input  logic              ovf
);
    logic zero_wr, clear_wr;
    logic chk_unused_bits;

    assign zero_wr  = bus_wr && bus_addr == RA_CTRL && bus_wdata[B_ZERO];
    assign clear_wr = bus_wr && bus_addr == RA_CTRL && !bus_wdata[B_FLAG];
    assign chk_unused_bits = ^{bus_wdata[6:5], bus_wdata[3:0]};

    // R7
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> (cnt == '0));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !zero_wr) |=> $stable(cnt));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !zero_wr && cnt == lim) |=> (cnt == '0));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !zero_wr && cnt != lim) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R10
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear_wr) |=> flag);

    // R9
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !ovf) |=> !flag);
endmodule

bind modulo_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tick      (tick_w),
    .cnt       (cnt_w),
    .lim       (lim_w),
    .flag      (flag_w),
    .stop      (stop_w),
    .ovf       (ovf_w)
);

// File: tb/modulo_timer_tb.sv
module modulo_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    modulo_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // driver: each call drives one bus cycle; the rising edge follows
    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic brd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_rd = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #3;
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq=%b expected %b", tag, irq, e);
        end
    endtask

    // monitor: pops the expected byte for every read cycle
    always @(negedge clk) begin
        #2;
        if (bus_rd) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read: rdata=%h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: finished=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R3 limit reset value
        brd(0, 8'h20, "R1 ctrl");
        brd(1, 8'h00, "R1 cnt hi");
        brd(2, 8'h00, "R1 cnt lo");
        brd(3, 8'hFF, "R3 lim hi");
        brd(4, 8'hFF, "R3 lim lo");
        idle(1);
        chk_irq(1'b0, "R1 irq");

        // R2 field layout, bits 4 and 3 read zero
        bwr(0, 8'h7D);
        brd(0, 8'h65, "R2 layout");
        bwr(0, 8'h20);

        // R3 counting at ratio 1, limit 10
        bwr(3, 8'h00);
        bwr(4, 8'h0A);
        brd(4, 8'h0A, "R3 lim readback");
        bwr(0, 8'h10);
        idle(6);
        bwr(0, 8'h20);
        brd(2, 8'h07, "R3 count");
        brd(1, 8'h00, "R3 count hi");
        brd(0, 8'h20, "R3 no flag yet");
        idle(5);
        brd(2, 8'h07, "R6 count held");

        // R5 reaching the limit, then wrap
        bwr(0, 8'h00);
        idle(2);
        bwr(0, 8'h20);
        brd(2, 8'h0A, "R5 at limit");
        brd(0, 8'hA0, "R5 flag set");
        bwr(0, 8'h80);
        bwr(0, 8'h20);
        brd(2, 8'h00, "R5 wrap");
        brd(0, 8'hA0, "R9 write one keeps");

        // R9 write of 0 without arming read
        bwr(0, 8'hA0);
        bwr(0, 8'h20);
        brd(0, 8'hA0, "R9 unarmed clear");

        // R11 interrupt follows flag and enable
        bwr(0, 8'hE0);
        idle(1);
        chk_irq(1'b1, "R11 irq high");
        brd(0, 8'hE0, "R8 arm read");
        bwr(0, 8'h60);
        idle(1);
        chk_irq(1'b0, "R11 irq low");
        brd(0, 8'h60, "R8 cleared");
        bwr(0, 8'hE0);
        brd(0, 8'h60, "R9 write one no set");

        // R10 overflow between read and write, limit 3
        bwr(3, 8'h00);
        bwr(4, 8'h03);
        bwr(0, 8'h10);
        idle(3);
        brd(0, 8'h80, "R10 arm read");
        idle(3);
        bwr(0, 8'h00);
        brd(0, 8'h80, "R10 cancelled clear");
        bwr(0, 8'h00);
        brd(0, 8'h00, "R8 clear while running");
        bwr(0, 8'h20);
        brd(2, 8'h00, "R5 wrap limit 3");

        // R4 prescale ratios over 100 clocks
        bwr(3, 8'hFF);
        bwr(4, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            int r;
            if (k == 1 || k == 4 || k == 6) continue;
            r = (k == 7) ? 64 : (1 << k);
            bwr(0, 8'h10 | 8'(k));
            idle(99);
            bwr(0, 8'h20 | 8'(k));
            brd(2, 8'(100 / r), "R4 ratio");
            brd(1, 8'h00, "R4 ratio hi");
        end

        // R7 zeroing, field update in the same write
        bwr(0, 8'h30);
        brd(2, 8'h00, "R7 count zeroed");
        brd(0, 8'hA0, "R7 fields");

        // R6 prescaler phase held across a stop
        bwr(0, 8'h12);
        idle(1);
        bwr(0, 8'h22);
        idle(5);
        bwr(0, 8'h02);
        idle(1);
        bwr(0, 8'h22);
        brd(2, 8'h01, "R6 phase held");

        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule